// File: doc/BRIEF.md
# Producer-Consumer Valid Tracking Memory

This block is a shared scratchpad that attaches one hardware validity flag to every data word. A producer core stores words through a write port. A consumer core fetches them through a read port that can ask for one word, a run of consecutive words, or a square neighbourhood of words around a centre address, as an image-processing kernel would. The flags take the place of software flags and barriers. A write can only land in an empty slot. A read only completes once every word it names has been filled, and a completed read empties those slots again. Each produced value is therefore handed over exactly once.

Both ports answer in the same cycle through a combinational ready signal. A requester whose ready is low keeps its request up and retries on the next cycle. A stalled request leaves data and flags untouched. A granted read delivers its words one cycle later on a wide lane bus, together with a one-cycle strobe. The row pitch of the neighbourhood, the burst limit, the neighbourhood size, the word width and the depth are all parameters.

Top module: `pcvm_mem`

## Requirements
- R1: Reset clears every validity flag. After reset no read is granted and a write to any address is accepted.
- R2: When `wr_req` is high and `wr_ready` is high, the word at `wr_addr` takes `wr_data` and its flag becomes set from the next cycle on. `wr_ready` is high exactly when the target word's flag is clear.
- R3: A read with `rd_mode` 0 (single), or with the reserved code 3, which behaves the same, touches only `rd_addr`. `rd_ready` is high exactly when every touched word is valid. In the cycle after a granted read, `rd_rvalid` is high for one cycle and `rd_data` lane 0 (bits 31:0) holds the word.
- R4: A granted read clears the flags of all the words it returns. Reading the same word again then stalls until it has been written anew.
- R5: While `rd_ready` is low, a pending read returns nothing (`rd_rvalid` stays low) and changes no flag and no data.
- R6: A write to a word whose flag is set is stalled. The stored value is kept and can later be read intact.
- R7: `rd_mode` 1 (burst) touches `rd_len`+1 consecutive words (1 to 8) starting at `rd_addr`, wrapping modulo the depth. Lane i carries word `rd_addr`+i, and lanes past the count read as zero. All flags of the range are checked together in one cycle.
- R8: `rd_mode` 2 (window) touches a 3x3 neighbourhood. Lane r*3+c (r,c = 0..2) carries word `rd_addr` + (r-1)*16 + (c-1), modulo the depth, with a row pitch of 16 words.
- R9: When a write and a read name the same word in one cycle, the read is judged on the flags from before the write. A read of an empty word stalls while the write lands. A write into a full word stalls while the read takes the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Producer write request |
| wr_addr | input | 8 | Producer word address |
| wr_data | input | 32 | Producer write data |
| wr_ready | output | 1 | Write accepted this cycle (target empty) |
| rd_req | input | 1 | Consumer read request |
| rd_mode | input | 2 | 0 single, 1 burst, 2 window, 3 as single |
| rd_addr | input | 8 | Start address (burst) or centre address (window) |
| rd_len | input | 3 | Burst word count minus one |
| rd_ready | output | 1 | All touched words valid; read granted if requested |
| rd_rvalid | output | 1 | Read data present, one cycle after grant |
| rd_data | output | 288 | Nine 32-bit lanes, lane 0 in the low bits |

## Verification
On every cycle, the checker holds that an accepted write leaves its word flagged, that a granted read leaves its first word unflagged and yields a data strobe, and that a stalled or absent read yields none. It also holds that a stalled write with no granted read leaves the flag vector unchanged, and that the flags are empty when reset lifts. Only the bench scenarios can show what is actually returned: the lane order of bursts and of wrapped windows, zeroed spare lanes, a value kept through a refused overwrite, and the read-before-write outcome when both ports meet on one word. A scoreboard compares each returned lane set against a flag-and-data model kept in the bench.

// File: rtl/pcvm_pkg.sv
package pcvm_pkg;

   typedef enum logic [1:0] {
      ACC_SINGLE = 2'd0,
      ACC_BURST  = 2'd1,
      ACC_WINDOW = 2'd2,
      ACC_RSVD   = 2'd3
   } acc_mode_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pcvm_lane_gen.sv
// Turns a read request into a list of lane addresses plus a mask of lanes in use.
module pcvm_lane_gen
   import pcvm_pkg::*;
#(
   parameter int AW        = 8,
   parameter int NLANES    = 9,
   parameter int MAX_BURST = 8,
   parameter int LEN_W     = 3,
   parameter int WIN       = 3,
   parameter int STRIDE    = 16
) (
   input  acc_mode_e                    mode,
   input  logic [AW-1:0]                base,
   input  logic [LEN_W-1:0]             len_m1,
   output logic [NLANES-1:0][AW-1:0]    lane_addr,
   output logic [NLANES-1:0]            lane_used
);

   localparam int HALF = WIN / 2;

   for (genvar i = 0; i < NLANES; i++) begin : g_lane
      localparam bit IN_BURST = (i < MAX_BURST);
      localparam bit IN_WIN   = (i < WIN * WIN);
      localparam int WOFF     = IN_WIN ? (((i / WIN) - HALF) * STRIDE + ((i % WIN) - HALF)) : 0;
      localparam logic [AW-1:0]    WOFF_V = AW'(WOFF);
      localparam logic [AW-1:0]    BOFF_V = AW'(i);
      localparam logic [LEN_W:0]   IDX    = (LEN_W+1)'(i);

      logic [AW-1:0] a;
      logic          u;

      always_comb begin
         a = base;
         u = 1'b0;
         case (mode)
            ACC_BURST: begin
               a = base + BOFF_V;
               u = IN_BURST && (IDX <= {1'b0, len_m1});
            end
            ACC_WINDOW: begin
               a = base + WOFF_V;
               u = IN_WIN;
            end
            default: begin
               a = base;
               u = (i == 0);
            end
         endcase
      end

      assign lane_addr[i] = a;
      assign lane_used[i] = u;
   end

endmodule

// File: rtl/pcvm_valid_track.sv
// Per-word validity flags: readiness of both ports and the set/clear update.
module pcvm_valid_track #(
   parameter int DEPTH  = 256,
   parameter int AW     = 8,
   parameter int NLANES = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_req,
   input  logic [AW-1:0]             wr_addr,
   input  logic                      rd_req,
   input  logic [NLANES-1:0][AW-1:0] lane_addr,
   input  logic [NLANES-1:0]         lane_used,
   output logic                      wr_ready,
   output logic                      rd_ready,
   output logic                      wr_go,
   output logic                      rd_go,
   output logic [DEPTH-1:0]          valid_vec
);

   logic [DEPTH-1:0]  valid_q;
   logic [DEPTH-1:0]  set_m;
   logic [DEPTH-1:0]  clr_m;
   logic [NLANES-1:0] lane_ok;

   always_comb begin
      for (int l = 0; l < NLANES; l++) begin
         lane_ok[l] = ~lane_used[l] | valid_q[lane_addr[l]];
      end
   end

   // Both decisions use the flags as they stood before this cycle.
   assign rd_ready = &lane_ok;
   assign wr_ready = ~valid_q[wr_addr];
   assign rd_go    = rd_req & rd_ready;
   assign wr_go    = wr_req & wr_ready;

   always_comb begin
      set_m = '0;
      clr_m = '0;
      if (wr_go) set_m[wr_addr] = 1'b1;
      for (int l = 0; l < NLANES; l++) begin
         if (rd_go && lane_used[l]) clr_m[lane_addr[l]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= (valid_q & ~clr_m) | set_m;
   end

   assign valid_vec = valid_q;

endmodule

// File: rtl/pcvm_word_store.sv
// Data array with one write port and NLANES registered read lanes.
module pcvm_word_store #(
   parameter int DW     = 32,
   parameter int DEPTH  = 256,
   parameter int AW     = 8,
   parameter int NLANES = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [DW-1:0]             wr_data,
   input  logic                      rd_en,
   input  logic [NLANES-1:0][AW-1:0] lane_addr,
   input  logic [NLANES-1:0]         lane_used,
   output logic [NLANES*DW-1:0]      rd_data,
   output logic                      rd_rvalid
);

   logic [DW-1:0]        mem [DEPTH];
   logic [NLANES*DW-1:0] rd_q;
   logic                 rv_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // Reads sample the array before this edge's write: read-before-write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
         rv_q <= 1'b0;
      end else begin
         rv_q <= rd_en;
         if (rd_en) begin
            for (int l = 0; l < NLANES; l++) begin
               rd_q[l*DW +: DW] <= lane_used[l] ? mem[lane_addr[l]] : '0;
            end
         end
      end
   end

   assign rd_data   = rd_q;
   assign rd_rvalid = rv_q;

endmodule

// File: rtl/pcvm_mem.sv
module pcvm_mem
   import pcvm_pkg::*;
#(
   parameter int DW        = 32,
   parameter int DEPTH     = 256,
   parameter int MAX_BURST = 8,
   parameter int WIN       = 3,
   parameter int STRIDE    = 16,
   localparam int AW       = $clog2(DEPTH),
   localparam int LEN_W    = $clog2(MAX_BURST),
   localparam int NLANES   = int'(max_of(MAX_BURST, WIN * WIN))
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_req,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   output logic                 wr_ready,
   input  logic                 rd_req,
   input  logic [1:0]           rd_mode,
   input  logic [AW-1:0]        rd_addr,
   input  logic [LEN_W-1:0]     rd_len,
   output logic                 rd_ready,
   output logic                 rd_rvalid,
   output logic [NLANES*DW-1:0] rd_data
);

   if (DW < 1)                         begin : g_bad_dw     $error("DW must be positive");            end
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth $error("DEPTH must be a power of two"); end
   if (MAX_BURST < 2)                  begin : g_bad_burst  $error("MAX_BURST must be at least 2");    end
   if ((WIN % 2) == 0)                 begin : g_bad_win    $error("WIN must be odd");                 end
   if (STRIDE < WIN || WIN * STRIDE > DEPTH) begin : g_bad_stride $error("STRIDE out of range");      end

   logic [NLANES-1:0][AW-1:0] lane_addr;
   logic [NLANES-1:0]         lane_used;
   logic                      wr_go;
   logic                      rd_go;
   logic [DEPTH-1:0]          valid_vec;

   pcvm_lane_gen #(
      .AW(AW), .NLANES(NLANES), .MAX_BURST(MAX_BURST),
      .LEN_W(LEN_W), .WIN(WIN), .STRIDE(STRIDE)
   ) u_lanes (
      .mode      (acc_mode_e'(rd_mode)),
      .base      (rd_addr),
      .len_m1    (rd_len),
      .lane_addr (lane_addr),
      .lane_used (lane_used)
   );

   pcvm_valid_track #(
      .DEPTH(DEPTH), .AW(AW), .NLANES(NLANES)
   ) u_valid (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .rd_req    (rd_req),
      .lane_addr (lane_addr),
      .lane_used (lane_used),
      .wr_ready  (wr_ready),
      .rd_ready  (rd_ready),
      .wr_go     (wr_go),
      .rd_go     (rd_go),
      .valid_vec (valid_vec)
   );

   pcvm_word_store #(
      .DW(DW), .DEPTH(DEPTH), .AW(AW), .NLANES(NLANES)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_go),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_en     (rd_go),
      .lane_addr (lane_addr),
      .lane_used (lane_used),
      .rd_data   (rd_data),
      .rd_rvalid (rd_rvalid)
   );

endmodule

// File: rtl/pcvm_checker.sv
module pcvm_checker #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_req,
   input logic [AW-1:0]    wr_addr,
   input logic             wr_ready,
   input logic             rd_req,
   input logic             rd_ready,
   input logic             rd_rvalid,
   input logic [AW-1:0]    lane0_addr,
   input logic [DEPTH-1:0] valid_vec
);

   // R1: flags are empty when reset lifts
   assert_reset_clear_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (valid_vec == '0));

   assert_write_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && wr_ready) |=> valid_vec[$past(wr_addr)]);

   assert_read_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ready) |=> rd_rvalid);

   assert_read_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_ready) |=> !valid_vec[$past(lane0_addr)]);

   assert_stall_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && rd_ready) |=> !rd_rvalid);

   assert_write_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ready && !(rd_req && rd_ready)) |=> $stable(valid_vec));

endmodule

bind pcvm_mem pcvm_checker #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_req     (wr_req),
   .wr_addr    (wr_addr),
   .wr_ready   (wr_ready),
   .rd_req     (rd_req),
   .rd_ready   (rd_ready),
   .rd_rvalid  (rd_rvalid),
   .lane0_addr (lane_addr[0]),
   .valid_vec  (valid_vec)
);

// File: tb/sim_pcvm_mem.sv
`timescale 1ns/1ps
module sim_pcvm_mem;

   localparam int DW = 32, DEPTH = 256, AW = 8, NL = 9, LW = 3, STRIDE = 16;
   localparam int BUSW = NL * DW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_req = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            wr_ready;
   logic            rd_req = 1'b0;
   logic [1:0]      rd_mode = 2'd0;
   logic [AW-1:0]   rd_addr = '0;
   logic [LW-1:0]   rd_len = '0;
   logic            rd_ready;
   logic            rd_rvalid;
   logic [BUSW-1:0] rd_data;

   always #2 clk = ~clk;

   pcvm_mem u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_req(rd_req), .rd_mode(rd_mode), .rd_addr(rd_addr), .rd_len(rd_len),
      .rd_ready(rd_ready), .rd_rvalid(rd_rvalid), .rd_data(rd_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit              m_valid [DEPTH];
   logic [DW-1:0]   m_mem   [DEPTH];
   logic [BUSW-1:0] exp_q   [$];
   string           tag_q   [$];

   task automatic chk(input bit ok, input string req, input logic [BUSW-1:0] act, input logic [BUSW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void lanes(input int mode, input int base, input int len_m1,
                                 output int a [NL], output bit u [NL]);
      for (int i = 0; i < NL; i++) begin
         a[i] = base; u[i] = 1'b0;
         if (mode == 1) begin
            a[i] = (base + i) & (DEPTH - 1); u[i] = (i < 8) && (i <= len_m1);
         end else if (mode == 2) begin
            a[i] = (base + (i / 3 - 1) * STRIDE + (i % 3 - 1)) & (DEPTH - 1); u[i] = 1'b1;
         end else begin
            u[i] = (i == 0);
         end
      end
   endfunction

   // Drive one cycle of requests, check readiness against the model, queue read results.
   task automatic step(input bit dw, input int wa, input logic [DW-1:0] wd,
                       input bit dr, input int mode, input int ra, input int len_m1, input string req);
      int a [NL]; bit u [NL]; bit rok; bit wok; logic [BUSW-1:0] ex;
      @(negedge clk);
      wr_req = dw; wr_addr = AW'(wa); wr_data = wd;
      rd_req = dr; rd_mode = 2'(mode); rd_addr = AW'(ra); rd_len = LW'(len_m1);
      #1;
      lanes(mode, ra, len_m1, a, u);
      rok = 1'b1; ex = '0;
      for (int i = 0; i < NL; i++) if (u[i]) begin
         rok &= m_valid[a[i]];
         ex[i*DW +: DW] = m_mem[a[i]];
      end
      wok = !m_valid[wa];
      if (dr) chk(rd_ready == rok, req, BUSW'(rd_ready), BUSW'(rok));
      if (dw) chk(wr_ready == wok, req, BUSW'(wr_ready), BUSW'(wok));
      if (dr && rok) begin
         exp_q.push_back(ex); tag_q.push_back(req);
         for (int i = 0; i < NL; i++) if (u[i]) m_valid[a[i]] = 1'b0;
      end
      if (dw && wok) begin
         m_valid[wa] = 1'b1; m_mem[wa] = wd;
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wr_req = 1'b0; rd_req = 1'b0;
      end
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d, input string req);
      step(1'b1, a, d, 1'b0, 0, 0, 0, req);
   endtask

   task automatic rd(input int mode, input int a, input int len_m1, input string req);
      step(1'b0, 0, '0, 1'b1, mode, a, len_m1, req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
      exp_q.delete(); tag_q.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Monitor: every strobe must match the oldest queued expectation.
   always @(negedge clk) begin
      if (rst_n && rd_rvalid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R5 unexpected strobe", rd_data, '0);
         end else begin
            logic [BUSW-1:0] e; string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk(rd_data == e, t, rd_data, e);
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_valid[i] = 1'b0; m_mem[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: nothing readable after reset, writes accepted
      @(negedge clk); #1;
      chk(rd_rvalid == 1'b0, "R1 strobe idle", BUSW'(rd_rvalid), '0);
      rd(0, 0, 0, "R1 read after reset");
      rd(2, 100, 0, "R1 window after reset");
      idle(1);
      // R2/R3/R4 single handover, then consumed
      wr(5, 32'hA5A5_0005, "R2");
      rd(0, 5, 0, "R3 single");
      rd(0, 5, 0, "R4 consumed word stalls");
      rd(3, 5, 0, "R3 reserved mode stalls");
      wr(6, 32'h0000_0666, "R2");
      rd(3, 6, 0, "R3 reserved mode as single");
      idle(2);
      // R6 refused overwrite keeps value
      wr(7, 32'h1111_1111, "R2");
      wr(7, 32'h2222_2222, "R6 write to full word");
      idle(1);
      rd(0, 7, 0, "R6 kept value");
      wr(7, 32'h3333_3333, "R6 accepted after read");
      rd(0, 7, 0, "R6 new value");
      idle(2);
      // R7 burst: partial fill stalls, full fill grants all eight
      for (int i = 10; i < 16; i++) wr(i, 32'hB000_0000 + i, "R2");
      rd(1, 10, 7, "R7 burst with gaps");
      rd(1, 10, 7, "R5 retry still stalled");
      wr(16, 32'hB000_0010, "R2");
      wr(17, 32'hB000_0011, "R2");
      rd(1, 10, 7, "R7 burst of eight");
      rd(1, 12, 0, "R4 burst consumed");
      wr(20, 32'hC0DE_0020, "R2");
      rd(1, 20, 0, "R7 burst of one");
      for (int i = 0; i < 4; i++) wr((254 + i) & 255, 32'hE000_0000 + i, "R2");
      rd(1, 254, 3, "R7 burst wraps");
      idle(2);
      // R8 window: missing centre stalls, then full grant
      for (int i = 0; i < 9; i++) if (i != 4)
         wr((40 + (i / 3 - 1) * STRIDE + (i % 3 - 1)) & 255, 32'hD000_0000 + i, "R2");
      rd(2, 40, 0, "R8 window missing centre");
      wr(40, 32'hD000_0004, "R2");
      rd(2, 40, 0, "R8 window grant");
      for (int i = 0; i < 9; i++)
         wr((0 + (i / 3 - 1) * STRIDE + (i % 3 - 1)) & 255, 32'hF000_0000 + i, "R2");
      rd(2, 0, 0, "R8 window wraps");
      idle(2);
      // R9 same-cycle ordering
      step(1'b1, 30, 32'h0000_9030, 1'b1, 0, 30, 0, "R9 read empty while writing");
      rd(0, 30, 0, "R9 write landed");
      wr(31, 32'h0000_A031, "R2");
      step(1'b1, 31, 32'h0000_B031, 1'b1, 0, 31, 0, "R9 write full while reading");
      rd(0, 31, 0, "R9 refused write left empty");
      wr(31, 32'h0000_B031, "R9 retry accepted");
      rd(0, 31, 0, "R9 new value");
      idle(2);
      // R1 mid-run reset clears flags
      wr(50, 32'h5050_5050, "R2");
      do_reset();
      rd(0, 50, 0, "R1 flag gone after reset");
      wr(50, 32'h5151_5151, "R1 write accepted after reset");
      idle(3);
      chk(exp_q.size() == 0, "R3 all reads returned", BUSW'(exp_q.size()), '0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule